// File: doc/BRIEF.md
# Video Sync Generator with Selectable Vertical Source

This block derives raster timing from an externally supplied pixel clock. A horizontal pixel counter runs freely on that clock in every mode and produces an active-low horizontal sync. A line counter advances once per line and produces an active-low vertical sync. A mode input selects where the vertical frame boundary comes from. In internal mode the block counts lines up to a programmed total. In external mode it follows the falling edge of a vertical sync input from an outside video decoder. That input is asynchronous, so it is resynchronised and edge-detected before use.

The horizontal and vertical syncs are combined into a single active-low composite sync, which is registered on the pixel clock. The block also provides line-start and frame-start strobes, together with the current pixel and line numbers, so that a downstream reader can pace its fetches from them. In external mode a watchdog margin limits how far the line counter can run when no external edge arrives, and horizontal timing carries on without a break. A change of mode is held back until the current frame ends.

Top module: `vid_sync_gen`

## Requirements
- R1: `pixel_o` counts 0 to `h_total_i`-1 and wraps to 0 on every clock in both modes; `line_start_o` is 1 exactly when `pixel_o` is 0.
- R2: `hsync_no` is 0 (active) while `pixel_o` < `h_width_i`, and 1 otherwise (`h_width_i` is at least 1).
- R3: In internal mode (mode value 0), `line_o` changes only when `pixel_o` returns to 0. It increments at each line end and wraps to 0 after line `v_total_i`-1.
- R4: In internal mode, `ext_vsync_ni` has no effect on `line_o` or on any sync output.
- R5: In external mode (mode value 1), a high-to-low transition on `ext_vsync_ni` is captured through two synchroniser flops plus an edge flop. It forces `line_o` to 0 at the next line start.
- R6: In external mode with no external edge, `line_o` wraps to 0 by itself after line `v_total_i` + `V_MARGIN` - 1 (default margin 4).
- R7: `vsync_no` is 0 while `line_o` < `v_width_i`, and 1 otherwise (`v_width_i` is at least 1).
- R8: `csync_no` is the AND of `hsync_no` and `vsync_no`. It is held in its own flop and is updated only on rising pixel-clock edges.
- R9: `frame_start_o` is 1 for exactly one clock, when `line_o` is 0 and `pixel_o` is 0.
- R10: A change on `ext_mode_i` takes effect only when the line counter wraps to 0. The frame in progress finishes under the old mode.
- R11: During reset, and until the first clock edge after reset, `pixel_o` and `line_o` are 0, all three syncs are 0, and the active mode is internal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | External pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_mode_i | input | 1 | Vertical source select: 1 external, 0 internal |
| ext_vsync_ni | input | 1 | Asynchronous active-low vertical sync from an outside decoder |
| h_total_i | input | HW | Pixels per line |
| h_width_i | input | HW | Horizontal sync width in pixels |
| v_total_i | input | LW | Lines per frame in internal mode |
| v_width_i | input | LW | Vertical sync width in lines |
| pixel_o | output | HW | Current pixel number |
| line_o | output | LW | Current line number |
| hsync_no | output | 1 | Horizontal sync, active low |
| vsync_no | output | 1 | Vertical sync, active low |
| csync_no | output | 1 | Composite sync, active low |
| line_start_o | output | 1 | Pulse at pixel 0 of every line |
| frame_start_o | output | 1 | Pulse at pixel 0 of line 0 |

## Verification
Two situations are hard to reach from the ports. The first is a mode change in the middle of a frame, which must not cut that frame short. The second is an external edge arriving after the line count has already passed the internal total. The bench raises the mode bit during line 1 and confirms that the frame still wraps at the internal total. It then withholds the external sync so that the count reaches the watchdog limit. After that it drops the input late in a line that lies beyond the internal total, so that the three-flop latency moves the captured edge into the following line. A final run with a second timing set toggles the external input at pseudo-random times, while a behavioural model is compared against the outputs on every clock.

// File: rtl/vsg_pkg.sv
package vsg_pkg;
  typedef enum logic {
    VSRC_INT = 1'b0,
    VSRC_EXT = 1'b1
  } vsrc_e;
endpackage

// File: rtl/vsg_hcount.sv
module vsg_hcount #(
  parameter int HW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [HW-1:0] h_total_i,
  input  logic [HW-1:0] h_width_i,
  output logic [HW-1:0] pix_o,
  output logic          line_end_o,
  output logic          hs_nxt_o,
  output logic          hsync_no
);
  logic [HW-1:0] pix_q, pix_d;

  assign line_end_o = (pix_q >= h_total_i - HW'(1));
  assign pix_d      = line_end_o ? '0 : pix_q + HW'(1);
  assign hs_nxt_o   = (pix_d >= h_width_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_q    <= '0;
      hsync_no <= 1'b0;
    end else begin
      pix_q    <= pix_d;
      hsync_no <= hs_nxt_o;
    end
  end

  assign pix_o = pix_q;
endmodule

// File: rtl/vsg_ext_sync.sv
module vsg_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_ni,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-1:0], async_ni};
  end

  // last stage is the edge-detect history flop
  assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/vsg_vcount.sv
module vsg_vcount
  import vsg_pkg::*;
#(
  parameter int LW       = 11,
  parameter int V_MARGIN = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_end_i,
  input  logic          ext_mode_i,
  input  logic          fall_i,
  input  logic [LW-1:0] v_total_i,
  input  logic [LW-1:0] v_width_i,
  output logic [LW-1:0] line_o,
  output logic          vs_nxt_o,
  output logic          vsync_no
);
  vsrc_e         mode_q;
  logic          pend_q, pend_d;
  logic          ext_act, hit, wrap;
  logic [LW-1:0] line_q, line_d, limit;

  assign ext_act = (mode_q == VSRC_EXT);
  assign hit     = ext_act & (pend_q | fall_i);
  assign limit   = ext_act ? v_total_i + LW'(V_MARGIN) - LW'(1)
                           : v_total_i - LW'(1);
  assign wrap    = hit | (line_q >= limit);
  assign line_d  = !line_end_i ? line_q : (wrap ? '0 : line_q + LW'(1));
  assign pend_d  = (!ext_act || line_end_i) ? 1'b0 : (pend_q | fall_i);
  assign vs_nxt_o = (line_d >= v_width_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q   <= '0;
      pend_q   <= 1'b0;
      mode_q   <= VSRC_INT;
      vsync_no <= 1'b0;
    end else begin
      line_q   <= line_d;
      pend_q   <= pend_d;
      vsync_no <= vs_nxt_o;
      // mode switches only on a frame wrap
      if (line_end_i && wrap) mode_q <= vsrc_e'(ext_mode_i);
    end
  end

  assign line_o = line_q;
endmodule

// File: rtl/vid_sync_gen.sv
module vid_sync_gen #(
  parameter int HW       = 12,
  parameter int LW       = 11,
  parameter int V_MARGIN = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ext_mode_i,
  input  logic          ext_vsync_ni,
  input  logic [HW-1:0] h_total_i,
  input  logic [HW-1:0] h_width_i,
  input  logic [LW-1:0] v_total_i,
  input  logic [LW-1:0] v_width_i,
  output logic [HW-1:0] pixel_o,
  output logic [LW-1:0] line_o,
  output logic          hsync_no,
  output logic          vsync_no,
  output logic          csync_no,
  output logic          line_start_o,
  output logic          frame_start_o
);
  logic line_end, hs_nxt, vs_nxt, fall;
  logic csync_q;

  vsg_hcount #(.HW(HW)) u_hcnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .h_total_i  (h_total_i),
    .h_width_i  (h_width_i),
    .pix_o      (pixel_o),
    .line_end_o (line_end),
    .hs_nxt_o   (hs_nxt),
    .hsync_no   (hsync_no)
  );

  vsg_ext_sync #(.STAGES(2)) u_esync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .async_ni (ext_vsync_ni),
    .fall_o   (fall)
  );

  vsg_vcount #(.LW(LW), .V_MARGIN(V_MARGIN)) u_vcnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_end_i (line_end),
    .ext_mode_i (ext_mode_i),
    .fall_i     (fall),
    .v_total_i  (v_total_i),
    .v_width_i  (v_width_i),
    .line_o     (line_o),
    .vs_nxt_o   (vs_nxt),
    .vsync_no   (vsync_no)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) csync_q <= 1'b0;
    else         csync_q <= hs_nxt & vs_nxt;
  end

  assign csync_no      = csync_q;
  assign line_start_o  = (pixel_o == '0);
  assign frame_start_o = (pixel_o == '0) && (line_o == '0);
endmodule

// File: rtl/vid_sync_gen_chk.sv
module vid_sync_gen_chk #(
  parameter int HW = 12,
  parameter int LW = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [HW-1:0] h_total_i,
  input logic [HW-1:0] h_width_i,
  input logic [HW-1:0] pixel_o,
  input logic [LW-1:0] line_o,
  input logic          hsync_no,
  input logic          vsync_no,
  input logic          csync_no,
  input logic          frame_start_o
);
  // R1
  pix_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pixel_o < h_total_i - HW'(1)) && $stable(h_total_i) |=> pixel_o == $past(pixel_o) + HW'(1));

  // R2
  hsync_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_width_i != '0) && $stable(h_width_i) |-> hsync_no == (pixel_o >= h_width_i));

  // R3
  line_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pixel_o != '0) |-> $stable(line_o));

  // R8
  csync_and_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csync_no == (hsync_no & vsync_no));

  // R9
  frame_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_total_i > HW'(1)) && frame_start_o |=> !frame_start_o);
endmodule

bind vid_sync_gen vid_sync_gen_chk #(.HW(HW), .LW(LW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .h_total_i     (h_total_i),
  .h_width_i     (h_width_i),
  .pixel_o       (pixel_o),
  .line_o        (line_o),
  .hsync_no      (hsync_no),
  .vsync_no      (vsync_no),
  .csync_no      (csync_no),
  .frame_start_o (frame_start_o)
);

// File: tb/vid_sync_gen_test.sv
module vid_sync_gen_test;
  localparam int HW = 12, LW = 11, MARGIN = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_mode = 1'b0, ext_vs = 1'b1;
  logic [HW-1:0] h_total = 10, h_width = 2;
  logic [LW-1:0] v_total = 6, v_width = 1;
  logic [HW-1:0] pixel_o;
  logic [LW-1:0] line_o;
  logic hsync_no, vsync_no, csync_no, line_start_o, frame_start_o;

  int checks = 0, errors = 0;
  bit model_on = 0;

  always #10 clk = ~clk;

  vid_sync_gen #(.HW(HW), .LW(LW), .V_MARGIN(MARGIN)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ext_mode_i(ext_mode), .ext_vsync_ni(ext_vs),
    .h_total_i(h_total), .h_width_i(h_width), .v_total_i(v_total), .v_width_i(v_width),
    .pixel_o(pixel_o), .line_o(line_o), .hsync_no(hsync_no), .vsync_no(vsync_no),
    .csync_no(csync_no), .line_start_o(line_start_o), .frame_start_o(frame_start_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // behavioural reference model
  int m_pix, m_line, m_mode, m_pend;
  int ext_hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pix = 0; m_line = 0; m_mode = 0; m_pend = 0;
      ext_hist = '{1, 1, 1};
    end else begin
      int ht, vt, nl, np;
      bit le, fall, hit, wrap;
      ht = int'(h_total); vt = int'(v_total);
      le = (m_pix >= ht - 1);
      // edge is visible three edges after the input moved
      fall = (ext_hist[1] == 0) && (ext_hist[2] == 1);
      hit = m_mode && (m_pend || fall);
      wrap = hit || (m_line >= (m_mode ? vt + MARGIN - 1 : vt - 1));
      nl = le ? (wrap ? 0 : m_line + 1) : m_line;
      np = (!m_mode || le) ? 0 : (m_pend || fall);
      if (le && wrap) m_mode = int'(ext_mode);
      m_line = nl; m_pend = np;
      m_pix = le ? 0 : m_pix + 1;
      ext_hist.push_front(int'(ext_vs));
      ext_hist.pop_back();
    end
  end

  always @(negedge clk) begin
    if (rst_n && model_on) begin
      int hs, vs;
      hs = (m_pix >= int'(h_width)) ? 1 : 0;
      vs = (m_line >= int'(v_width)) ? 1 : 0;
      chk("R1", int'(pixel_o), m_pix);
      chk("R1", int'(line_start_o), (m_pix == 0) ? 1 : 0);
      chk("R2", int'(hsync_no), hs);
      if (m_mode != 0) chk("R5", int'(line_o), m_line);
      else             chk("R3", int'(line_o), m_line);
      chk("R7", int'(vsync_no), vs);
      chk("R8", int'(csync_no), hs & vs);
      chk("R9", int'(frame_start_o), (m_pix == 0 && m_line == 0) ? 1 : 0);
    end
  end

  task automatic wait_pos(int l, int p);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (int'(line_o) == l && int'(pixel_o) == p) return;
    end
    chk("wait", 0, 1);
  endtask

  task automatic wait_pix0();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (pixel_o == '0) return;
    end
    chk("wait", 0, 1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset values
    chk("R11", int'(pixel_o), 0);
    chk("R11", int'(line_o), 0);
    chk("R11", int'(hsync_no), 0);
    chk("R11", int'(vsync_no), 0);
    chk("R11", int'(csync_no), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    do_reset();
    model_on = 1;
    repeat (130) @(negedge clk);

    // R4: external edges ignored in internal mode
    wait_pos(2, 3);
    ext_vs = 1'b0;
    repeat (5) @(negedge clk);
    ext_vs = 1'b1;
    wait_pix0();
    chk("R4", int'(line_o), 3);

    // R10: mode raised mid-frame, current frame still wraps at internal total
    wait_pos(1, 0);
    ext_mode = 1'b1;
    wait_pos(5, 9);
    @(negedge clk);
    chk("R10", int'(line_o), 0);

    // R6: no external edge, counter runs past total up to watchdog limit
    wait_pos(6, 0);
    chk("R6", int'(line_o), 6);
    wait_pos(9, 9);
    @(negedge clk);
    chk("R6", int'(line_o), 0);

    // R5: edge within a line resets at the next line start
    wait_pos(3, 4);
    ext_vs = 1'b0;
    wait_pix0();
    chk("R5", int'(line_o), 0);
    repeat (12) @(negedge clk);
    ext_vs = 1'b1;

    // R5: late edge beyond internal total, captured in the following line
    wait_pos(7, 8);
    ext_vs = 1'b0;
    wait_pos(8, 9);
    @(negedge clk);
    chk("R5", int'(line_o), 0);
    ext_vs = 1'b1;
    repeat (40) @(negedge clk);

    // back to internal mode
    ext_mode = 1'b0;
    repeat (200) @(negedge clk);

    // second timing set, external mode with irregular edges
    model_on = 0;
    h_total = 7; h_width = 3; v_total = 4; v_width = 2;
    ext_mode = 1'b1;
    do_reset();
    model_on = 1;
    for (int i = 0; i < 60; i++) begin
      repeat (5 + ($urandom % 40)) @(negedge clk);
      ext_vs = ~ext_vs;
    end
    ext_vs = 1'b1;
    repeat (100) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule